// File: doc/BRIEF.md
# Locked Index/Data Register Arbiter

This block puts a small indexed byte file behind two separate index/data register pairs. The host reaches the file through two consecutive I/O addresses: an index port at the base address, 0x70 by default, and a data port at base+1. The embedded core reaches the same file through its own index and data registers, which it selects with a two-bit register select. Each side keeps its own index, and a data access always uses the index that belongs to the side making it.

A single ownership lock bit, held in a core-side control register, decides which side owns the file. While the bit is 0 the host owns the file. While it is 1 the core owns it. The side that does not own the file loses all of its accesses: its writes change nothing and its reads return 0xFF. Core accesses also need the `active_mode` input to be high.

The lock register and a window onto the host index let core firmware do the following. It takes the file, saves the host's index and reads or writes entries. Then it puts the host index back and releases the lock, so the host finds the file as it left it.

Top module: `lida_top`

## Requirements
- R1: After a synchronous reset the lock bit is 0 (`core_owns` low), so the host owns the file. The host index and the core index are both 0.
- R2: While the lock is 0, a host write to the base address loads the low 7 bits of the written byte into the host index, which wraps the index modulo the 128-entry file depth. A host read of the base address returns the index zero-extended to 8 bits.
- R3: While the lock is 0, a host write to base+1 stores the byte in the entry the host index selects. A host read of base+1 returns that entry.
- R4: A read on either side answers with its `rvalid` high and its data exactly one clock after the request cycle. A host access to any address other than base or base+1 gets no response and changes nothing.
- R5: While the lock is 1, host writes to base and base+1 are ignored, and host reads of either address return 0xFF.
- R6: Core register select 3 is the lock register. With `active_mode` high, a write loads bit 0 of the data into the lock and a read returns the lock in bit 0 with the other bits 0. With `active_mode` low, writes to it are ignored and reads return 0xFF.
- R7: While the lock is 1 and `active_mode` is high, core select 0 reads and writes the core index (low 7 bits, wrapping as in R2). Core select 1 reads and writes the file entry the core index selects.
- R8: While the lock is 0 or `active_mode` is low, core writes to selects 0, 1 and 2 are ignored, and core reads of those selects return 0xFF.
- R9: While the lock is 1 and `active_mode` is high, core select 2 reads the host index and a write to it loads the host index. A restored host index is what the host reads back after the lock is released.
- R10: Both sides reach one shared file. An entry written by one side is read back unchanged by the other side after ownership passes to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_mode | input | 1 | High when the controller is in Active mode; gates every core access |
| host_req | input | 1 | Host I/O access strobe, one cycle per access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_rvalid | output | 1 | Host read response valid |
| host_rdata | output | 8 | Host read data |
| core_req | input | 1 | Core access strobe, one cycle per access |
| core_we | input | 1 | Core access is a write |
| core_sel | input | 2 | Core register: 0 core index, 1 data, 2 host index, 3 lock |
| core_wdata | input | 8 | Core write data |
| core_rvalid | output | 1 | Core read response valid |
| core_rdata | output | 8 | Core read data |
| core_owns | output | 1 | Current lock bit; high while the core owns the file |

## Verification
The bench goes after the hand-over points. It checks that host writes made while the core holds the lock leave no trace in the file, and a design that let them through would show the host's byte when the core reads that entry back. It writes index bytes with bit 7 set: a design that kept bit 7 or stored the full byte would address the wrong entry or echo the wrong index. It also drops `active_mode` while the core holds the lock and accesses the lock register while inactive, which catches a core port that checks only the lock or ignores the mode. Finally it restores a different host index through the core's window and looks for that value and its entry from the host side after release. A design that left the host index alone or restored it into the core's own index would fail there.

// File: rtl/lida_pkg.sv
package lida_pkg;

    // Width of every data path at the block edge.
    localparam int BYTE_W = 8;

    // Value a locked-out read produces.
    localparam logic [BYTE_W-1:0] BLOCKED_BYTE = 8'hFF;

    // Core-side register select encoding.
    typedef enum logic [1:0] {
        SEL_CIDX = 2'd0,
        SEL_DATA = 2'd1,
        SEL_HIDX = 2'd2,
        SEL_LOCK = 2'd3
    } core_sel_e;

    // Registered read response of one side.
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rsp_t;

    // Gate a read value: a side that may not access returns the blocked byte.
    function automatic logic [BYTE_W-1:0] gate_read(input logic permitted,
                                                    input logic [BYTE_W-1:0] value);
        return permitted ? value : BLOCKED_BYTE;
    endfunction

endpackage

// File: rtl/lida_regfile.sv
module lida_regfile #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    parameter int NRD   = 2
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [$clog2(DEPTH)-1:0]    wr_idx,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic [NRD-1:0][$clog2(DEPTH)-1:0] rd_idx,
    output logic [NRD-1:0][WIDTH-1:0]   rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // One asynchronous read path per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] a;
        assign a          = rd_idx[p];
        assign rd_data[p] = mem[a];
    end

endmodule

// File: rtl/lida_host_port.sv
module lida_host_port
    import lida_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0070,
    parameter int                IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              owner_core,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              restore_en,
    input  logic [IDX_W-1:0]  restore_val,
    input  logic [BYTE_W-1:0] file_rdata,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output rsp_t              rsp
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE + ADDR_W'(1);

    logic allowed, hit_idx, hit_dat;
    logic [IDX_W-1:0] idx_q;
    rsp_t rsp_d, rsp_q;

    assign allowed = !owner_core;
    assign hit_idx = req && (addr == BASE);
    assign hit_dat = req && (addr == DATA_ADDR);

    // The core restore only happens while the core owns the file, so it
    // never meets a permitted host index write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (restore_en) begin
            idx_q <= restore_val;
        end else if (hit_idx && we && allowed) begin
            idx_q <= wdata[IDX_W-1:0];
        end
    end

    assign idx     = idx_q;
    assign wr_en   = hit_dat && we && allowed;
    assign wr_idx  = idx_q;
    assign wr_data = wdata;

    always_comb begin
        rsp_d.valid = (hit_idx || hit_dat) && !we;
        rsp_d.data  = gate_read(allowed, hit_idx ? BYTE_W'(idx_q) : file_rdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp = rsp_q;

endmodule

// File: rtl/lida_core_port.sv
module lida_core_port
    import lida_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [BYTE_W-1:0] file_rdata,
    output logic              lock,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              hidx_wr_en,
    output logic [IDX_W-1:0]  hidx_wr_val,
    output rsp_t              rsp
);
    core_sel_e sel_e;
    logic ok_lock, ok_file, do_wr;
    logic lock_q;
    logic [IDX_W-1:0] idx_q;
    rsp_t rsp_d, rsp_q;

    assign sel_e   = core_sel_e'(sel);
    assign ok_lock = active;
    assign ok_file = active && lock_q;
    assign do_wr   = req && we;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (do_wr && sel_e == SEL_LOCK && ok_lock) begin
            lock_q <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (do_wr && sel_e == SEL_CIDX && ok_file) begin
            idx_q <= wdata[IDX_W-1:0];
        end
    end

    assign lock        = lock_q;
    assign idx         = idx_q;
    assign wr_en       = do_wr && sel_e == SEL_DATA && ok_file;
    assign wr_idx      = idx_q;
    assign wr_data     = wdata;
    assign hidx_wr_en  = do_wr && sel_e == SEL_HIDX && ok_file;
    assign hidx_wr_val = wdata[IDX_W-1:0];

    always_comb begin
        rsp_d.valid = req && !we;
        unique case (sel_e)
            SEL_LOCK: rsp_d.data = gate_read(ok_lock, BYTE_W'(lock_q));
            SEL_CIDX: rsp_d.data = gate_read(ok_file, BYTE_W'(idx_q));
            SEL_HIDX: rsp_d.data = gate_read(ok_file, BYTE_W'(host_idx));
            default:  rsp_d.data = gate_read(ok_file, file_rdata);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp = rsp_q;

endmodule

// File: rtl/lida_top.sv
module lida_top
    import lida_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] HOST_BASE = 16'h0070,
    parameter int                DEPTH     = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_mode,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_rvalid,
    output logic [7:0]        host_rdata,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [1:0]        core_sel,
    input  logic [7:0]        core_wdata,
    output logic              core_rvalid,
    output logic [7:0]        core_rdata,
    output logic              core_owns
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              lock;
    logic [IDX_W-1:0]  host_idx, core_idx;
    logic              host_wr_en, core_wr_en, file_we;
    logic [IDX_W-1:0]  host_wr_idx, core_wr_idx, file_widx;
    logic [BYTE_W-1:0] host_wr_data, core_wr_data, file_wdata;
    logic              hidx_wr_en;
    logic [IDX_W-1:0]  hidx_wr_val;
    logic [1:0][IDX_W-1:0]  rd_idx;
    logic [1:0][BYTE_W-1:0] rd_data;
    rsp_t              host_rsp, core_rsp;

    lida_host_port #(.ADDR_W(ADDR_W), .BASE(HOST_BASE), .IDX_W(IDX_W)) u_host (
        .clk         (clk),
        .rst         (rst),
        .owner_core  (lock),
        .req         (host_req),
        .we          (host_we),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .restore_en  (hidx_wr_en),
        .restore_val (hidx_wr_val),
        .file_rdata  (rd_data[0]),
        .idx         (host_idx),
        .wr_en       (host_wr_en),
        .wr_idx      (host_wr_idx),
        .wr_data     (host_wr_data),
        .rsp         (host_rsp)
    );

    lida_core_port #(.IDX_W(IDX_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .active      (active_mode),
        .req         (core_req),
        .we          (core_we),
        .sel         (core_sel),
        .wdata       (core_wdata),
        .host_idx    (host_idx),
        .file_rdata  (rd_data[1]),
        .lock        (lock),
        .idx         (core_idx),
        .wr_en       (core_wr_en),
        .wr_idx      (core_wr_idx),
        .wr_data     (core_wr_data),
        .hidx_wr_en  (hidx_wr_en),
        .hidx_wr_val (hidx_wr_val),
        .rsp         (core_rsp)
    );

    // Ownership makes the two write enables exclusive; the select below
    // only has to pick the one that is live.
    assign file_we    = host_wr_en || core_wr_en;
    assign file_widx  = core_wr_en ? core_wr_idx  : host_wr_idx;
    assign file_wdata = core_wr_en ? core_wr_data : host_wr_data;

    assign rd_idx[0] = host_idx;
    assign rd_idx[1] = core_idx;

    lida_regfile #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .NRD(2)) u_file (
        .clk     (clk),
        .wr_en   (file_we),
        .wr_idx  (file_widx),
        .wr_data (file_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign host_rvalid = host_rsp.valid;
    assign host_rdata  = host_rsp.data;
    assign core_rvalid = core_rsp.valid;
    assign core_rdata  = core_rsp.data;
    assign core_owns   = lock;

endmodule

// File: rtl/lida_checker.sv
module lida_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] HOST_BASE = 16'h0070
) (
    input logic              clk,
    input logic              rst,
    input logic              active_mode,
    input logic              host_req,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rvalid,
    input logic [7:0]        host_rdata,
    input logic              core_req,
    input logic              core_we,
    input logic [1:0]        core_sel,
    input logic              core_rvalid,
    input logic [7:0]        core_rdata,
    input logic              core_owns,
    input logic              host_wr_en,
    input logic              core_wr_en
);
    logic host_hit;
    assign host_hit = host_req &&
                      (host_addr == HOST_BASE || host_addr == HOST_BASE + ADDR_W'(1));

    // R4: a host read to the pair is answered one cycle later
    a_r4_host_answer: assert property (@(posedge clk) disable iff (rst)
        (host_hit && !host_we) |=> host_rvalid);

    // R4: nothing else produces a host response
    a_r4_host_silent: assert property (@(posedge clk) disable iff (rst)
        !(host_hit && !host_we) |=> !host_rvalid);

    // R4: every core read is answered one cycle later
    a_r4_core_answer: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_we) |=> core_rvalid);

    // R5: a locked-out host read returns the blocked byte
    a_r5_host_blocked: assert property (@(posedge clk) disable iff (rst)
        (core_owns && host_hit && !host_we) |=> (host_rdata == 8'hFF));

    // R5: no host write reaches the file while the core owns it
    a_r5_host_no_write: assert property (@(posedge clk) disable iff (rst)
        core_owns |-> !host_wr_en);

    // R8: no core write reaches the file without ownership and Active mode
    a_r8_core_no_write: assert property (@(posedge clk) disable iff (rst)
        (!core_owns || !active_mode) |-> !core_wr_en);

    // R8: a blocked core read returns the blocked byte
    a_r8_core_blocked: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_we && core_sel != 2'd3 && (!core_owns || !active_mode))
        |=> (core_rdata == 8'hFF));

    // R6: the lock only moves on an Active-mode write to its register
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (!active_mode || !(core_req && core_we && core_sel == 2'd3))
        |=> $stable(core_owns));

    // R10: only one side ever writes the shared file in a cycle
    a_r10_one_writer: assert property (@(posedge clk) disable iff (rst)
        !(host_wr_en && core_wr_en));

endmodule

bind lida_top lida_checker #(.ADDR_W(ADDR_W), .HOST_BASE(HOST_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .active_mode (active_mode),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .core_req    (core_req),
    .core_we     (core_we),
    .core_sel    (core_sel),
    .core_rvalid (core_rvalid),
    .core_rdata  (core_rdata),
    .core_owns   (core_owns),
    .host_wr_en  (host_wr_en),
    .core_wr_en  (core_wr_en)
);

// File: tb/lida_top_bench.sv
module lida_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        active_mode;
    logic        host_req, host_we;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_rvalid;
    logic [7:0]  host_rdata;
    logic        core_req, core_we;
    logic [1:0]  core_sel;
    logic [7:0]  core_wdata;
    logic        core_rvalid;
    logic [7:0]  core_rdata;
    logic        core_owns;

    int total = 0;
    int bad   = 0;
    bit timed_out = 0;

    logic [7:0] hq_exp [$];
    string      hq_tag [$];
    logic [7:0] cq_exp [$];
    string      cq_tag [$];

    always #5 clk = ~clk;

    lida_top u_lida_top (
        .clk         (clk),
        .rst         (rst),
        .active_mode (active_mode),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .core_req    (core_req),
        .core_we     (core_we),
        .core_sel    (core_sel),
        .core_wdata  (core_wdata),
        .core_rvalid (core_rvalid),
        .core_rdata  (core_rdata),
        .core_owns   (core_owns)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_acc(input bit we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic core_acc(input bit we, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_sel = s; core_wdata = d;
        @(negedge clk);
        core_req = 1'b0; core_we = 1'b0;
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        host_acc(1'b1, a, d);
    endtask

    task automatic host_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        hq_exp.push_back(exp); hq_tag.push_back(tag);
        host_acc(1'b0, a, 8'h00);
    endtask

    task automatic core_wr(input logic [1:0] s, input logic [7:0] d);
        core_acc(1'b1, s, d);
    endtask

    task automatic core_rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
        cq_exp.push_back(exp); cq_tag.push_back(tag);
        core_acc(1'b0, s, 8'h00);
    endtask

    task automatic run_tests();
        // R1: reset state
        check(core_owns == 1'b0, "R1 lock after reset", core_owns, 0);
        host_rd(16'h0070, 8'h00, "R1 host index after reset");
        core_rd(2'd3, 8'h00, "R1 lock register after reset");

        // R2: host index load, readback, wrap
        host_wr(16'h0070, 8'h05);
        host_rd(16'h0070, 8'h05, "R2 host index readback");
        host_wr(16'h0070, 8'h85);
        host_rd(16'h0070, 8'h05, "R2 index wraps modulo 128");

        // R3: host data through its index
        host_wr(16'h0071, 8'hA5);
        host_wr(16'h0070, 8'h10);
        host_wr(16'h0071, 8'h3C);
        host_wr(16'h0070, 8'h05);
        host_rd(16'h0071, 8'hA5, "R3 host data entry 5");
        host_wr(16'h0070, 8'h10);
        host_rd(16'h0071, 8'h3C, "R3 host data entry 0x10");

        // R8: core locked out while lock is 0
        core_wr(2'd0, 8'h05);
        core_wr(2'd1, 8'h77);
        core_wr(2'd2, 8'h33);
        core_rd(2'd1, 8'hFF, "R8 core data blocked");
        core_rd(2'd0, 8'hFF, "R8 core index blocked");
        core_rd(2'd2, 8'hFF, "R8 host index window blocked");
        host_rd(16'h0070, 8'h10, "R8 blocked core write left host index");
        host_rd(16'h0071, 8'h3C, "R8 blocked core write left file");

        // R4: foreign addresses are silent and harmless
        host_acc(1'b0, 16'h0072, 8'h00);
        check(host_rvalid == 1'b0, "R4 no response to 0x72", host_rvalid, 0);
        host_wr(16'h006F, 8'h55);
        host_wr(16'h0170, 8'h01);
        host_rd(16'h0070, 8'h10, "R4 foreign write left index");
        host_rd(16'h0071, 8'h3C, "R4 foreign write left file");

        // R6: lock register gated by Active mode
        active_mode = 1'b0;
        core_wr(2'd3, 8'h01);
        core_rd(2'd3, 8'hFF, "R6 lock register inactive read");
        @(negedge clk);
        check(core_owns == 1'b0, "R6 inactive lock write ignored", core_owns, 0);
        active_mode = 1'b1;
        core_wr(2'd3, 8'h01);
        @(negedge clk);
        check(core_owns == 1'b1, "R6 lock taken", core_owns, 1);
        core_rd(2'd3, 8'h01, "R6 lock register readback");

        // R9: save host index
        core_rd(2'd2, 8'h10, "R9 core reads host index");

        // R5: host locked out
        host_wr(16'h0070, 8'h22);
        host_wr(16'h0071, 8'h99);
        host_rd(16'h0070, 8'hFF, "R5 host index read blocked");
        host_rd(16'h0071, 8'hFF, "R5 host data read blocked");
        core_rd(2'd2, 8'h10, "R5 blocked host index write ignored");

        // R7 / R10: core index and data
        core_wr(2'd0, 8'h05);
        core_rd(2'd0, 8'h05, "R7 core index readback");
        core_rd(2'd1, 8'hA5, "R10 core sees host-written entry");
        core_wr(2'd1, 8'h5A);
        core_rd(2'd1, 8'h5A, "R7 core data readback");
        core_wr(2'd0, 8'h90);
        core_rd(2'd0, 8'h10, "R7 core index wraps");
        core_rd(2'd1, 8'h3C, "R5 blocked host data write ignored");
        core_wr(2'd0, 8'h20);
        core_wr(2'd1, 8'hC3);

        // R9: restore a host index
        core_wr(2'd2, 8'h20);
        core_rd(2'd2, 8'h20, "R9 host index written by core");

        // R8: inactive while locked
        active_mode = 1'b0;
        core_wr(2'd1, 8'h11);
        core_rd(2'd1, 8'hFF, "R8 inactive core data blocked");
        active_mode = 1'b1;
        core_rd(2'd1, 8'hC3, "R8 inactive core write ignored");

        // release
        core_wr(2'd3, 8'h00);
        @(negedge clk);
        check(core_owns == 1'b0, "R6 lock released", core_owns, 0);
        host_rd(16'h0070, 8'h20, "R9 host sees restored index");
        host_rd(16'h0071, 8'hC3, "R10 host sees core-written entry");
        host_wr(16'h0070, 8'h05);
        host_rd(16'h0071, 8'h5A, "R10 host sees core data at 5");

        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; active_mode = 1'b1;
        host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        core_req = 1'b0; core_we = 1'b0; core_sel = '0; core_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // monitor: compare responses against the expected queues
        fork
            forever begin
                @(negedge clk);
                if (host_rvalid) begin
                    if (hq_exp.size() == 0) begin
                        check(1'b0, "R4 unexpected host response", host_rdata, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = hq_exp.pop_front(); t = hq_tag.pop_front();
                        check(host_rdata == e, t, host_rdata, e);
                    end
                end
                if (core_rvalid) begin
                    if (cq_exp.size() == 0) begin
                        check(1'b0, "R4 unexpected core response", core_rdata, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = cq_exp.pop_front(); t = cq_tag.pop_front();
                        check(core_rdata == e, t, core_rdata, e);
                    end
                end
            end
        join_none

        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;

        if (timed_out) begin
            check(1'b0, "watchdog expired", 1, 0);
        end
        check(hq_exp.size() == 0, "R4 missing host responses", hq_exp.size(), 0);
        check(cq_exp.size() == 0, "R4 missing core responses", cq_exp.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule